// File: doc/BRIEF.md
# Flash Command Controller

This block sits between a host-side write/read bus and the internals of a NOR-style flash device. It decodes one-cycle and two-cycle command writes on a 16-bit data bus. It chooses what a read returns: array data, identifier words, query data or the status word. It runs a modelled write engine for program and erase, whose busy time is a parameterised cycle count. That engine can be suspended and resumed, and a program may run and be suspended while an erase is already suspended.

The cells, the supply sensing and the real timing stay outside the block. A single `vpp_ok` input stands for the supply check. An external lock manager is looked up through `lk_addr` and answers with the block's locked, locked-down and allowed flags. Lock commands are forwarded to that manager as a one-cycle request. Array and query data arrive on input buses and are passed through in the matching read mode.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (`rd_mode` = 0), `busy` is 0, `status` reads 0080h and `rd_data` equals `arr_rdata`.
- R2: Data byte FFh selects array mode (0), 90h selects identifier mode (1), 98h selects query mode (2) and 70h selects status mode (3). `rd_data` returns `arr_rdata`, identifier data, `qry_rdata` or `status` to match the mode.
- R3: In identifier mode, address 0 reads 00B0h and address 1 reads 00A0h. An address whose offset inside its block (low BLK_LSB bits) is 2 reads {14'b0, lk_down, lk_locked}. Every other address reads 0.
- R4: Data byte 40h or 10h, followed by any data word, starts a program on an allowed block. `busy` is high for exactly PROG_CYC cycles and then `status` returns to 0080h. The read mode becomes status from the first cycle of any two-cycle command.
- R5: 20h then D0h (block erase) and 30h then D0h (full chip erase) each keep `busy` high for exactly ERASE_CYC cycles.
- R6: A second cycle with an invalid code (erase or lock setup not followed by a valid confirm code) sets status bits 5 and 4. No operation starts.
- R7: When an operation's target is not allowed, it aborts and sets bit 1. When `vpp_ok` is 0, it aborts and sets bit 3. The supply check wins if both apply. Neither case raises `busy`.
- R8: Error bits 5, 4, 3 and 1 stay set across later successful operations until a 50h write clears them.
- R9: Bits 15..8 and bit 0 always read 0. While `busy` is high the whole status word reads 0, so bit 7 (ready) is 0.
- R10: B0h written during a program makes the block ready on the next cycle with bit 2 set. D0h then resumes the program. The total busy time is still PROG_CYC.
- R11: A block erase suspended by B0h shows bit 6. A program may then run and be suspended in turn, giving bits 6 and 2. Resume continues the program first; that program uses PROG_CYC busy cycles in total and leaves bit 6 set. A second resume completes the erase.
- R12: B0h has no effect on a full chip erase or an OTP program (C0h then data). An OTP program issued while an erase is suspended sets bit 4 and does not start.
- R13: 60h followed by 01h, D0h or 2Fh pulses `lk_cmd_valid` for one cycle, in the cycle after the confirm write. `lk_cmd_op` is 0 for set, 1 for clear and 2 for lock-down. `lk_cmd_addr` carries the confirm address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_addr | input | AW | Command write address |
| wr_data | input | 16 | Command or data word |
| rd_addr | input | AW | Read address |
| rd_data | output | 16 | Read data for the current mode |
| arr_rdata | input | 16 | Array data supplied from outside |
| qry_rdata | input | 16 | Query data supplied from outside |
| vpp_ok | input | 1 | Programming supply adequate |
| lk_addr | output | AW | Lookup address for the lock manager (write address while `wr_en`, else read address) |
| lk_locked | input | 1 | Looked-up block is locked |
| lk_down | input | 1 | Looked-up block is locked down |
| lk_allowed | input | 1 | Looked-up block may be erased or programmed |
| lk_cmd_valid | output | 1 | Lock command request pulse |
| lk_cmd_op | output | 2 | Lock command: 0 set, 1 clear, 2 lock-down |
| lk_cmd_addr | output | AW | Lock command address |
| busy | output | 1 | Write engine running |
| status | output | 16 | Status word |
| rd_mode | output | 2 | Current read mode |

## Verification
A corrupted suspend flag or saved count shows up in `status` in the cycle after the next B0h or D0h write. It appears as a wrong bit 2 or bit 6, or as a busy run that is too long or too short after resume. A lost or stuck error bit shows in the status word read after the failing command, and again after a 50h clear. A wrong pending-command state shows within one cycle of the second write: as a missing `busy` rise, an unexpected 00B0h status, or an absent `lk_cmd_valid` pulse. Counting busy cycles across suspend and resume exposes off-by-one errors in the remaining-count bookkeeping.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_QUERY = 2'd2, RM_STATUS = 2'd3} rmode_e;
  typedef enum logic [2:0] {OP_IDLE, OP_PROG, OP_ERASE, OP_CHIP, OP_OTP} wop_e;
  typedef enum logic [2:0] {PD_NONE, PD_ERASE, PD_CHIP, PD_PROG, PD_LOCK, PD_OTP} pend_e;
  typedef enum logic [1:0] {LK_SET = 2'd0, LK_CLR = 2'd1, LK_DOWN = 2'd2} lkop_e;

  localparam logic [7:0] C_RD_ARRAY = 8'hFF;
  localparam logic [7:0] C_RD_IDENT = 8'h90;
  localparam logic [7:0] C_RD_QUERY = 8'h98;
  localparam logic [7:0] C_RD_STAT  = 8'h70;
  localparam logic [7:0] C_CLR_STAT = 8'h50;
  localparam logic [7:0] C_SUSPEND  = 8'hB0;
  localparam logic [7:0] C_CONFIRM  = 8'hD0;
  localparam logic [7:0] C_ERASE    = 8'h20;
  localparam logic [7:0] C_CHIP     = 8'h30;
  localparam logic [7:0] C_PROG_A   = 8'h40;
  localparam logic [7:0] C_PROG_B   = 8'h10;
  localparam logic [7:0] C_LOCK     = 8'h60;
  localparam logic [7:0] C_OTP      = 8'hC0;
  localparam logic [7:0] C_LK_SET   = 8'h01;
  localparam logic [7:0] C_LK_DOWN  = 8'h2F;
endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic          busy,
  input  logic          psusp,
  input  logic          esusp,
  input  logic          vpp_ok,
  input  logic          lk_allowed,
  output logic          start,
  output wop_e          start_op,
  output logic          susp_req,
  output logic          resume_req,
  output logic          set_eerr,
  output logic          set_perr,
  output logic          set_vpp,
  output logic          set_lock,
  output logic          clr_sts,
  output rmode_e        rd_mode,
  output logic          lk_cmd_valid,
  output lkop_e         lk_cmd_op,
  output logic [AW-1:0] lk_cmd_addr
);
  pend_e  pend_q, pend_d;
  rmode_e mode_q, mode_d;
  logic   lkv_q, lkv_d;
  lkop_e  lkop_q, lkop_d;
  logic [AW-1:0] lka_q;
  logic [7:0] code;

  assign code = wr_data[7:0];

  // gate an operation start on supply, then on block permission
  function automatic logic [2:0] gate(input logic v_ok, input logic allow, input logic use_lock);
    if (!v_ok)                 gate = 3'b010;  // supply abort
    else if (use_lock && !allow) gate = 3'b001; // lock abort
    else                       gate = 3'b100;  // go
  endfunction

  always_comb begin
    logic [2:0] g;
    pend_d     = pend_q;
    mode_d     = mode_q;
    lkv_d      = 1'b0;
    lkop_d     = lkop_q;
    start      = 1'b0;
    start_op   = OP_IDLE;
    susp_req   = 1'b0;
    resume_req = 1'b0;
    set_eerr   = 1'b0;
    set_perr   = 1'b0;
    set_vpp    = 1'b0;
    set_lock   = 1'b0;
    clr_sts    = 1'b0;
    g          = 3'b000;
    if (wr_en) begin
      if (busy) begin
        if (code == C_SUSPEND) susp_req = 1'b1;
        if (code == C_RD_STAT) mode_d = RM_STATUS;
      end else if (pend_q != PD_NONE) begin
        pend_d = PD_NONE;
        case (pend_q)
          PD_ERASE, PD_CHIP: begin
            if (code != C_CONFIRM || psusp || esusp) begin
              set_eerr = 1'b1;
              set_perr = 1'b1;
            end else begin
              g = gate(vpp_ok, lk_allowed, 1'b1);
              start    = g[2];
              set_vpp  = g[1];
              set_lock = g[0];
              start_op = (pend_q == PD_CHIP) ? OP_CHIP : OP_ERASE;
            end
          end
          PD_PROG: begin
            if (psusp) begin
              set_eerr = 1'b1;
              set_perr = 1'b1;
            end else begin
              g = gate(vpp_ok, lk_allowed, 1'b1);
              start    = g[2];
              set_vpp  = g[1];
              set_lock = g[0];
              start_op = OP_PROG;
            end
          end
          PD_OTP: begin
            if (esusp || psusp) begin
              set_perr = 1'b1;
            end else begin
              g = gate(vpp_ok, lk_allowed, 1'b0);
              start    = g[2];
              set_vpp  = g[1];
              start_op = OP_OTP;
            end
          end
          PD_LOCK: begin
            if (code == C_LK_SET) begin
              lkv_d = 1'b1; lkop_d = LK_SET;
            end else if (code == C_CONFIRM) begin
              lkv_d = 1'b1; lkop_d = LK_CLR;
            end else if (code == C_LK_DOWN) begin
              lkv_d = 1'b1; lkop_d = LK_DOWN;
            end else begin
              set_eerr = 1'b1;
              set_perr = 1'b1;
            end
          end
          default: ;
        endcase
      end else begin
        case (code)
          C_RD_ARRAY: mode_d = RM_ARRAY;
          C_RD_IDENT: mode_d = RM_IDENT;
          C_RD_QUERY: mode_d = RM_QUERY;
          C_RD_STAT:  mode_d = RM_STATUS;
          C_CLR_STAT: clr_sts = 1'b1;
          C_CONFIRM: begin
            if (psusp || esusp) begin
              resume_req = 1'b1;
              mode_d     = RM_STATUS;
            end
          end
          C_ERASE:           begin pend_d = PD_ERASE; mode_d = RM_STATUS; end
          C_CHIP:            begin pend_d = PD_CHIP;  mode_d = RM_STATUS; end
          C_PROG_A, C_PROG_B: begin pend_d = PD_PROG; mode_d = RM_STATUS; end
          C_LOCK:            begin pend_d = PD_LOCK;  mode_d = RM_STATUS; end
          C_OTP:             begin pend_d = PD_OTP;   mode_d = RM_STATUS; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PD_NONE;
      mode_q <= RM_ARRAY;
      lkv_q  <= 1'b0;
      lkop_q <= LK_SET;
      lka_q  <= '0;
    end else begin
      pend_q <= pend_d;
      mode_q <= mode_d;
      lkv_q  <= lkv_d;
      if (lkv_d) begin
        lkop_q <= lkop_d;
        lka_q  <= wr_addr;
      end
    end
  end

  assign rd_mode      = mode_q;
  assign lk_cmd_valid = lkv_q;
  assign lk_cmd_op    = lkop_q;
  assign lk_cmd_addr  = lka_q;
endmodule

// File: rtl/nor_cmd_wsm.sv
module nor_cmd_wsm
  import nor_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  wop_e start_op,
  input  logic susp_req,
  input  logic resume_req,
  output logic busy,
  output logic psusp,
  output logic esusp
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  wop_e          op_q, op_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] psav_q, psav_d, esav_q, esav_d;
  logic          ps_q, ps_d, es_q, es_d;

  always_comb begin
    op_d   = op_q;
    cnt_d  = cnt_q;
    psav_d = psav_q;
    esav_d = esav_q;
    ps_d   = ps_q;
    es_d   = es_q;
    if (op_q == OP_IDLE) begin
      if (start) begin
        op_d  = start_op;
        cnt_d = (start_op == OP_PROG || start_op == OP_OTP) ? CW'(PROG_CYC - 1) : CW'(ERASE_CYC - 1);
      end else if (resume_req) begin
        if (ps_q) begin
          op_d  = OP_PROG;
          cnt_d = psav_q;
          ps_d  = 1'b0;
        end else if (es_q) begin
          op_d  = OP_ERASE;
          cnt_d = esav_q;
          es_d  = 1'b0;
        end
      end
    end else begin
      if (cnt_q == '0) begin
        op_d = OP_IDLE;
      end else if (susp_req && op_q == OP_PROG) begin
        op_d   = OP_IDLE;
        ps_d   = 1'b1;
        psav_d = cnt_q - 1'b1;
      end else if (susp_req && op_q == OP_ERASE) begin
        op_d   = OP_IDLE;
        es_d   = 1'b1;
        esav_d = cnt_q - 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      cnt_q  <= '0;
      psav_q <= '0;
      esav_q <= '0;
      ps_q   <= 1'b0;
      es_q   <= 1'b0;
    end else begin
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      psav_q <= psav_d;
      esav_q <= esav_d;
      ps_q   <= ps_d;
      es_q   <= es_d;
    end
  end

  assign busy  = (op_q != OP_IDLE);
  assign psusp = ps_q;
  assign esusp = es_q;
endmodule

// File: rtl/nor_cmd_status.sv
module nor_cmd_status
  import nor_cmd_pkg::*;
#(
  parameter int          AW       = 21,
  parameter int          BLK_LSB  = 16,
  parameter logic [15:0] MFR_CODE = 16'h00B0,
  parameter logic [15:0] DEV_CODE = 16'h00A0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          psusp,
  input  logic          esusp,
  input  logic          set_eerr,
  input  logic          set_perr,
  input  logic          set_vpp,
  input  logic          set_lock,
  input  logic          clr_sts,
  input  rmode_e        rd_mode,
  input  logic [AW-1:0] rd_addr,
  input  logic          lk_locked,
  input  logic          lk_down,
  input  logic [15:0]   arr_rdata,
  input  logic [15:0]   qry_rdata,
  output logic [15:0]   status,
  output logic [15:0]   rd_data,
  output logic          eerr_o
);
  localparam logic [BLK_LSB-1:0] CFG_OFS = BLK_LSB'(2);

  logic eerr_q, perr_q, vpp_q, lock_q;
  logic eerr_d, perr_d, vpp_d, lock_d;
  logic [15:0] id_word;

  always_comb begin
    eerr_d = eerr_q;
    perr_d = perr_q;
    vpp_d  = vpp_q;
    lock_d = lock_q;
    if (clr_sts) begin
      eerr_d = 1'b0;
      perr_d = 1'b0;
      vpp_d  = 1'b0;
      lock_d = 1'b0;
    end
    if (set_eerr) eerr_d = 1'b1;
    if (set_perr) perr_d = 1'b1;
    if (set_vpp)  vpp_d  = 1'b1;
    if (set_lock) lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      vpp_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      eerr_q <= eerr_d;
      perr_q <= perr_d;
      vpp_q  <= vpp_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    if (busy) status = 16'h0000;
    else      status = {8'h00, 1'b1, esusp, eerr_q, perr_q, vpp_q, psusp, lock_q, 1'b0};
  end

  always_comb begin
    if (rd_addr == AW'(0))                   id_word = MFR_CODE;
    else if (rd_addr == AW'(1))              id_word = DEV_CODE;
    else if (rd_addr[BLK_LSB-1:0] == CFG_OFS) id_word = {14'h0, lk_down, lk_locked};
    else                                     id_word = 16'h0000;
  end

  always_comb begin
    case (rd_mode)
      RM_ARRAY: rd_data = arr_rdata;
      RM_IDENT: rd_data = id_word;
      RM_QUERY: rd_data = qry_rdata;
      default:  rd_data = status;
    endcase
  end

  assign eerr_o = eerr_q;
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int          AW        = 21,
  parameter int          BLK_LSB   = 16,
  parameter int          PROG_CYC  = 16,
  parameter int          ERASE_CYC = 64,
  parameter logic [15:0] MFR_CODE  = 16'h00B0,
  parameter logic [15:0] DEV_CODE  = 16'h00A0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  input  logic [15:0]   arr_rdata,
  input  logic [15:0]   qry_rdata,
  input  logic          vpp_ok,
  output logic [AW-1:0] lk_addr,
  input  logic          lk_locked,
  input  logic          lk_down,
  input  logic          lk_allowed,
  output logic          lk_cmd_valid,
  output logic [1:0]    lk_cmd_op,
  output logic [AW-1:0] lk_cmd_addr,
  output logic          busy,
  output logic [15:0]   status,
  output logic [1:0]    rd_mode
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic   start_w, susp_req_w, resume_req_w;
  wop_e   start_op_w;
  logic   set_eerr_w, set_perr_w, set_vpp_w, set_lock_w, clr_sts_w;
  logic   psusp_w, esusp_w, eerr_w;
  rmode_e mode_w;
  lkop_e  lkop_w;

  assign lk_addr = wr_en ? wr_addr : rd_addr;

  nor_cmd_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .psusp(psusp_w), .esusp(esusp_w),
    .vpp_ok(vpp_ok), .lk_allowed(lk_allowed),
    .start(start_w), .start_op(start_op_w),
    .susp_req(susp_req_w), .resume_req(resume_req_w),
    .set_eerr(set_eerr_w), .set_perr(set_perr_w),
    .set_vpp(set_vpp_w), .set_lock(set_lock_w), .clr_sts(clr_sts_w),
    .rd_mode(mode_w),
    .lk_cmd_valid(lk_cmd_valid), .lk_cmd_op(lkop_w), .lk_cmd_addr(lk_cmd_addr)
  );

  nor_cmd_wsm #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_int_n),
    .start(start_w), .start_op(start_op_w),
    .susp_req(susp_req_w), .resume_req(resume_req_w),
    .busy(busy), .psusp(psusp_w), .esusp(esusp_w)
  );

  nor_cmd_status #(.AW(AW), .BLK_LSB(BLK_LSB), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_sts (
    .clk(clk), .rst_n(rst_int_n),
    .busy(busy), .psusp(psusp_w), .esusp(esusp_w),
    .set_eerr(set_eerr_w), .set_perr(set_perr_w),
    .set_vpp(set_vpp_w), .set_lock(set_lock_w), .clr_sts(clr_sts_w),
    .rd_mode(mode_w), .rd_addr(rd_addr),
    .lk_locked(lk_locked), .lk_down(lk_down),
    .arr_rdata(arr_rdata), .qry_rdata(qry_rdata),
    .status(status), .rd_data(rd_data), .eerr_o(eerr_w)
  );

  assign rd_mode   = mode_w;
  assign lk_cmd_op = lkop_w;
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        busy,
  input logic        psusp,
  input logic        esusp,
  input logic        resume_req,
  input logic        eerr,
  input logic [15:0] status,
  input logic        lk_cmd_valid
);
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15:8] == 8'h00) && (status[0] == 1'b0));

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status[6:1] == 6'h00));

  p_start_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  p_lock_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    lk_cmd_valid |=> !lk_cmd_valid);

  p_susp_by_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psusp) |-> $past(wr_en && (wr_data[7:0] == 8'hB0)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eerr) |-> $past(wr_en && (wr_data[7:0] == 8'h50)));

  p_prog_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (psusp && esusp && resume_req) |=> (!psusp && esusp && busy));
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_data(wr_data),
  .busy(busy), .psusp(psusp_w), .esusp(esusp_w), .resume_req(resume_req_w),
  .eerr(eerr_w), .status(status), .lk_cmd_valid(lk_cmd_valid)
);

// File: tb/nor_cmd_ctrl_tb_top.sv
module nor_cmd_ctrl_tb_top;
  localparam int AW = 8;
  localparam int BL = 4;
  localparam int PC = 4;
  localparam int EC = 8;
  localparam int NB = 1 << (AW - BL);

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [AW-1:0] wr_addr, rd_addr, lk_addr, lk_cmd_addr;
  logic [15:0] wr_data, rd_data, status;
  logic [15:0] arr_rdata, qry_rdata;
  logic vpp_ok, lk_locked, lk_down, lk_allowed, lk_cmd_valid, busy;
  logic [1:0] lk_cmd_op, rd_mode;

  logic blk_l [NB];
  logic blk_d [NB];
  int n_chk = 0;
  int n_fail = 0;
  int bcnt = 0;

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.AW(AW), .BLK_LSB(BL), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .arr_rdata(arr_rdata), .qry_rdata(qry_rdata),
    .vpp_ok(vpp_ok), .lk_addr(lk_addr), .lk_locked(lk_locked), .lk_down(lk_down),
    .lk_allowed(lk_allowed), .lk_cmd_valid(lk_cmd_valid), .lk_cmd_op(lk_cmd_op),
    .lk_cmd_addr(lk_cmd_addr), .busy(busy), .status(status), .rd_mode(rd_mode)
  );

  // bench lock manager
  assign lk_locked  = blk_l[lk_addr[AW-1:BL]];
  assign lk_down    = blk_d[lk_addr[AW-1:BL]];
  assign lk_allowed = !blk_l[lk_addr[AW-1:BL]];

  always @(posedge clk) begin
    if (lk_cmd_valid) begin
      case (lk_cmd_op)
        2'd0: blk_l[lk_cmd_addr[AW-1:BL]] <= 1'b1;
        2'd1: if (!blk_d[lk_cmd_addr[AW-1:BL]]) blk_l[lk_cmd_addr[AW-1:BL]] <= 1'b0;
        default: begin
          blk_l[lk_cmd_addr[AW-1:BL]] <= 1'b1;
          blk_d[lk_cmd_addr[AW-1:BL]] <= 1'b1;
        end
      endcase
    end
  end

  always @(negedge clk) if (busy) bcnt++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    finish_run();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin blk_l[b] = 1'b1; blk_d[b] = 1'b0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    arr_rdata = 16'h1234; qry_rdata = 16'hABCD; vpp_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 mode", {14'h0, rd_mode}, 16'd0);
    chk("R1 status", status, 16'h0080);
    chk("R1 busy", {15'h0, busy}, 16'h0);
    chk("R1 rd_data", rd_data, 16'h1234);

    // R2 read modes
    wr(16'h0090, 8'h00);
    chk("R2 ident mode", {14'h0, rd_mode}, 16'd1);
    chk("R2 ident data", rd_data, 16'h00B0);
    wr(16'h0098, 8'h00);
    chk("R2 query mode", {14'h0, rd_mode}, 16'd2);
    chk("R2 query data", rd_data, 16'hABCD);
    wr(16'h0070, 8'h00);
    chk("R2 status mode", {14'h0, rd_mode}, 16'd3);
    chk("R2 status data", rd_data, 16'h0080);
    wr(16'h00FF, 8'h00);
    chk("R2 array mode", {14'h0, rd_mode}, 16'd0);
    chk("R2 array data", rd_data, 16'h1234);

    // R13 lock commands
    wr(16'h0060, 8'h35);
    chk("R4 status mode after setup", {14'h0, rd_mode}, 16'd3);
    wr(16'h00D0, 8'h35);
    chk("R13 clear valid", {15'h0, lk_cmd_valid}, 16'h1);
    chk("R13 clear op", {14'h0, lk_cmd_op}, 16'd1);
    chk("R13 clear addr", {8'h0, lk_cmd_addr}, 16'h0035);
    @(negedge clk);
    chk("R13 pulse width", {15'h0, lk_cmd_valid}, 16'h0);
    wr(16'h0060, 8'h52); wr(16'h002F, 8'h52);
    chk("R13 down op", {14'h0, lk_cmd_op}, 16'd2);
    chk("R13 down addr", {8'h0, lk_cmd_addr}, 16'h0052);
    wr(16'h0060, 8'h60); wr(16'h00D0, 8'h60);
    wr(16'h0060, 8'h61); wr(16'h0001, 8'h61);
    chk("R13 set op", {14'h0, lk_cmd_op}, 16'd0);
    chk("R13 set valid", {15'h0, lk_cmd_valid}, 16'h1);

    // R3 identifier sweep
    wr(16'h0090, 8'h00);
    for (int a = 0; a < (1 << AW); a++) begin
      logic [15:0] e;
      rd_addr = AW'(a);
      #1;
      if (a == 0) e = 16'h00B0;
      else if (a == 1) e = 16'h00A0;
      else if ((a % (1 << BL)) == 2) e = {14'h0, blk_d[a >> BL], blk_l[a >> BL]};
      else e = 16'h0000;
      chk("R3 ident word", rd_data, e);
    end
    rd_addr = '0;

    // R6 improper sequences
    wr(16'h0020, 8'h30); wr(16'h0055, 8'h30);
    chk("R6 bad erase confirm", status, 16'h00B0);
    chk("R6 no start", {15'h0, busy}, 16'h0);
    // R8 sticky across a good program
    bcnt = 0;
    wr(16'h0040, 8'h31); wr(16'h7777, 8'h31); wait_idle();
    chk("R8 sticky after program", status, 16'h00B0);
    wr(16'h0050, 8'h00);
    chk("R8 cleared", status, 16'h0080);
    wr(16'h0060, 8'h30); wr(16'h0077, 8'h30);
    chk("R6 bad lock confirm", status, 16'h00B0);
    chk("R6 no lock request", {15'h0, lk_cmd_valid}, 16'h0);
    wr(16'h0050, 8'h00);

    // R7 aborts
    bcnt = 0;
    wr(16'h0040, 8'h05); wr(16'h1111, 8'h05);
    chk("R7 locked abort", status, 16'h0082);
    chk("R7 locked no busy", bcnt[15:0], 16'd0);
    wr(16'h0050, 8'h00);
    vpp_ok = 1'b0;
    wr(16'h0020, 8'h30); wr(16'h00D0, 8'h30);
    chk("R7 supply abort", status, 16'h0088);
    chk("R7 supply no busy", bcnt[15:0], 16'd0);
    vpp_ok = 1'b1;
    wr(16'h0050, 8'h00);
    chk("R8 clear after aborts", status, 16'h0080);

    // R4 program with 10h; R9 quiet while busy
    bcnt = 0;
    wr(16'h0010, 8'h33); wr(16'h4242, 8'h33);
    chk("R9 busy status word", status, 16'h0000);
    wait_idle();
    chk("R4 program busy cycles", bcnt[15:0], 16'(PC));
    chk("R4 done status", status, 16'h0080);
    chk("R4 read mode status", {14'h0, rd_mode}, 16'd3);

    // R5 erase and chip erase
    bcnt = 0;
    wr(16'h0020, 8'h34); wr(16'h00D0, 8'h34); wait_idle();
    chk("R5 block erase cycles", bcnt[15:0], 16'(EC));
    bcnt = 0;
    wr(16'h0030, 8'h30); wr(16'h00D0, 8'h30); wait_idle();
    chk("R5 chip erase cycles", bcnt[15:0], 16'(EC));
    chk("R5 done status", status, 16'h0080);

    // R10 program suspend and resume
    bcnt = 0;
    wr(16'h0040, 8'h32); wr(16'h2222, 8'h32);
    wr(16'h00B0, 8'h00);
    chk("R10 suspended status", status, 16'h0084);
    chk("R10 ready when suspended", {15'h0, busy}, 16'h0);
    wr(16'h00D0, 8'h00); wait_idle();
    chk("R10 total busy", bcnt[15:0], 16'(PC));
    chk("R10 done status", status, 16'h0080);

    // R11 nested suspend, program resumes first
    wr(16'h0020, 8'h30); wr(16'h00D0, 8'h30);
    wr(16'h00B0, 8'h00);
    chk("R11 erase suspended", status, 16'h00C0);
    bcnt = 0;
    wr(16'h0040, 8'h31); wr(16'h3333, 8'h31);
    wr(16'h00B0, 8'h00);
    chk("R11 both suspended", status, 16'h00C4);
    wr(16'h00D0, 8'h00); wait_idle();
    chk("R11 program busy", bcnt[15:0], 16'(PC));
    chk("R11 erase still suspended", status, 16'h00C0);
    wr(16'h00D0, 8'h00);
    chk("R11 erase resumed", {15'h0, busy}, 16'h1);
    wait_idle();
    chk("R11 all done", status, 16'h0080);

    // R12 unsuspendable operations
    bcnt = 0;
    wr(16'h0030, 8'h30); wr(16'h00D0, 8'h30); wr(16'h00B0, 8'h00); wait_idle();
    chk("R12 chip erase ignores suspend", bcnt[15:0], 16'(EC));
    chk("R12 chip erase status", status, 16'h0080);
    bcnt = 0;
    wr(16'h00C0, 8'h84); wr(16'h5555, 8'h84); wr(16'h00B0, 8'h00); wait_idle();
    chk("R12 otp ignores suspend", bcnt[15:0], 16'(PC));
    wr(16'h0020, 8'h30); wr(16'h00D0, 8'h30); wr(16'h00B0, 8'h00);
    wr(16'h00C0, 8'h85); wr(16'h6666, 8'h85);
    chk("R12 otp rejected", status, 16'h00D0);
    chk("R12 otp no busy", {15'h0, busy}, 16'h0);
    wr(16'h0050, 8'h00);
    chk("R8 clear keeps suspend", status, 16'h00C0);
    wr(16'h00D0, 8'h00); wait_idle();
    chk("R12 final status", status, 16'h0080);

    finish_run();
  end
endmodule